// File: doc/BRIEF.md
# Serial Control Register Port

This block is the configuration front end of a multichannel audio converter. A host drives three slow lines: a serial clock, a serial data line and a latch strobe. The block samples all three into its own system clock domain, shifts in one bit on each rising edge of the serial clock (most significant bit first) and, when the latch strobe rises after exactly sixteen bits, decodes the captured word and writes its 10-bit payload into one of nine configuration registers. The port is write-only.

A command word carries a 4-bit register selector in bits 15:12, two bits 11:10 that must be zero, and the payload in bits 9:0. Three selectors reach control words, six reach per-channel volume words, and the remaining seven are reserved. Commands aimed at a reserved selector, carrying a nonzero reserved bit, or asking for a code point the map leaves undefined are thrown away whole. The control words are presented to the rest of the chip as named, registered configuration fields; the volume words are presented side by side on one flat bus.

Top module: `scp_top`

## Requirements
- R1: After reset every control field output is zero and every volume word is all ones (10'h3FF, no attenuation).
- R2: A command is taken MSB first, one bit per rising edge of `ser_clk`, and is applied only when `ser_latch` rises after exactly 16 such edges; the settings appear at the outputs a few system clocks later.
- R3: Selector 4'h0 writes control word A, 4'h1 control word B, 4'h8 control word C, and 4'h2 through 4'h7 write the volume of channels 1 through 6; channel k (counting from 1) sits at `vol[(k-1)*10 +: 10]`.
- R4: Control word A drives `deemph_sel` from bits 9:8, `fmt_sel` from bits 7:5 (0 I2S, 1 right-justified, 2 DSP, 3 left-justified, 4 packed 256, 5 packed 128, 6 TDM), `wlen_sel` from bits 4:3 (0 = 24, 1 = 20, 2 = 16 bits), `pwr_down` from bit 2 and `interp_sel` from bits 1:0 (0 = 8x, 1 = 2x, 2 = 4x).
- R5: Control word B bits 5:0 drive `mute[5:0]`, bit 0 for channel 1 up to bit 5 for channel 6, 1 meaning muted.
- R6: Control word C drives `stereo_copy` from bit 5, `mclk_factor` from bits 4:3 (0 = x2, 1 = x1, 2 = x2/3), `zflag_low` from bit 2 (0 = active high flags) and `tdm_slave` from bit 0.
- R7: A command with a selector from 4'h9 to 4'hF changes no output.
- R8: A command is discarded, changing no output, when bits 11:10 are not zero, when word A carries format 3'b111, length 2'b11 or interpolation 2'b11, when word B has any of bits 9:6 set, or when word C has any of bits 9:6 or bit 1 set or factor 2'b11.
- R9: A latch rise after any bit count other than 16 (for example 15 or 17) drops the word and clears the bit count, so the next 16-bit command is applied normally.
- R10: Outputs change only when an accepted command is applied; serial clock activity without a latch leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock from the host, asynchronous |
| ser_dat | input | 1 | Serial command data, asynchronous |
| ser_latch | input | 1 | Commit strobe, rising edge applies the word |
| deemph_sel | output | 2 | De-emphasis curve select |
| fmt_sel | output | 3 | Audio serial format select |
| wlen_sel | output | 2 | Audio word length select |
| pwr_down | output | 1 | Power-down request |
| interp_sel | output | 2 | Interpolation ratio select |
| mute | output | 6 | Per-channel mute, bit 0 = channel 1 |
| stereo_copy | output | 1 | Copy channel pair 1 onto pairs 2 and 3 |
| mclk_factor | output | 2 | Master clock scaling select |
| zflag_low | output | 1 | Zero flags active low when set |
| tdm_slave | output | 1 | TDM port acts as slave when set |
| vol | output | 60 | Six 10-bit volume words, channel 1 lowest |

## Verification
The hardest state to reach is a latch rise that arrives with a bit count other than sixteen, followed by a good word whose acceptance depends on the counter having been cleared, and equally serial clock pulses left hanging without any latch so that the next command is silently overlong. The bench produces these by directed 15-, 17- and unlatched bit bursts and by random commands whose length is occasionally 15 or 17, while a bench model tracks the pending bit count to know which words should land. Random selectors and sparse reserved-bit patterns exercise every discard rule against the same model.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
package scp_pkg;
  localparam int WORD_BITS = 16;
  localparam int SEL_BITS  = 4;
  localparam int PAY_BITS  = 10;
  localparam int NUM_VOL   = 6;
  localparam int SYNC_DEPTH = 2;

  localparam logic [SEL_BITS-1:0] SEL_CTLA     = 4'h0;
  localparam logic [SEL_BITS-1:0] SEL_CTLB     = 4'h1;
  localparam logic [SEL_BITS-1:0] SEL_VOL_BASE = 4'h2;
  localparam logic [SEL_BITS-1:0] SEL_CTLC     = 4'h8;
endpackage

// File: rtl/scp_sync.sv
`timescale 1ns/1ps
module scp_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [DEPTH:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[DEPTH-1:0], d_i};
  end

  assign lvl_o  = pipe[DEPTH-1];
  assign rise_o = pipe[DEPTH-1] & ~pipe[DEPTH];
endmodule

// File: rtl/scp_shifter.sv
`timescale 1ns/1ps
module scp_shifter #(
  parameter int WB = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb_i,
  input  logic          bit_i,
  input  logic          latch_stb_i,
  output logic          commit_o,
  output logic [WB-1:0] word_o
);
  localparam int CW   = $clog2(2*WB);
  localparam logic [CW-1:0] CMAX = CW'(2*WB-1);
  localparam logic [CW-1:0] CFULL = CW'(WB);

  logic [WB-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      cnt_q    <= '0;
      commit_o <= 1'b0;
      word_o   <= '0;
    end else begin
      commit_o <= 1'b0;
      if (latch_stb_i) begin
        cnt_q    <= '0;
        word_o   <= sh_q;
        commit_o <= (cnt_q == CFULL);
      end else if (bit_stb_i) begin
        sh_q <= {sh_q[WB-2:0], bit_i};
        if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9: latch always clears the count
  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    latch_stb_i |=> cnt_q == '0);
  // R2: a commit only follows a full 16-bit count
  p_commit_full_r2: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> $past(cnt_q) == CFULL && $past(latch_stb_i));
  // R9: a count other than full never commits
  p_drop_short_r9: assert property (@(posedge clk) disable iff (rst)
    latch_stb_i && cnt_q != CFULL |=> !commit_o);
endmodule

// File: rtl/scp_regfile.sv
`timescale 1ns/1ps
module scp_regfile
  import scp_pkg::*;
#(
  parameter int WB = WORD_BITS,
  parameter int AW = SEL_BITS,
  parameter int DW = PAY_BITS,
  parameter int NV = NUM_VOL
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           commit_i,
  input  logic [WB-1:0]  word_i,
  output logic [DW-1:0]  ctla_o,
  output logic [DW-1:0]  ctlb_o,
  output logic [DW-1:0]  ctlc_o,
  output logic [NV*DW-1:0] vol_o
);
  localparam int RW = WB - AW - DW;
  localparam logic [AW-1:0] VBASE = SEL_VOL_BASE;
  localparam logic [AW-1:0] VEND  = AW'(int'(SEL_VOL_BASE) + NV);

  logic [AW-1:0] sel;
  logic [RW-1:0] rsv;
  logic [DW-1:0] pay;
  logic          ok_a, ok_b, ok_c, clean;
  logic          we_a, we_b, we_c, we_v;
  logic [AW-1:0] vidx;

  assign sel  = word_i[WB-1 -: AW];
  assign rsv  = word_i[DW +: RW];
  assign pay  = word_i[DW-1:0];
  assign vidx = sel - VBASE;

  always_comb begin
    ok_a  = (pay[7:5] != 3'b111) && (pay[4:3] != 2'b11) && (pay[1:0] != 2'b11);
    ok_b  = (pay[9:6] == 4'b0000);
    ok_c  = (pay[9:6] == 4'b0000) && !pay[1] && (pay[4:3] != 2'b11);
    clean = commit_i && (rsv == '0);
    we_a  = clean && (sel == SEL_CTLA) && ok_a;
    we_b  = clean && (sel == SEL_CTLB) && ok_b;
    we_c  = clean && (sel == SEL_CTLC) && ok_c;
    we_v  = clean && (sel >= VBASE) && (sel < VEND);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla_o <= '0;
      ctlb_o <= '0;
      ctlc_o <= '0;
    end else begin
      if (we_a) ctla_o <= pay;
      if (we_b) ctlb_o <= pay;
      if (we_c) ctlc_o <= pay;
    end
  end

  for (genvar g = 0; g < NV; g++) begin : g_vol
    logic [DW-1:0] v_q;
    always_ff @(posedge clk) begin
      if (rst)                             v_q <= '1;
      else if (we_v && vidx == AW'(g))     v_q <= pay;
    end
    assign vol_o[g*DW +: DW] = v_q;
  end

  // R10: nothing moves without a commit
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !commit_i |=> $stable(ctla_o) && $stable(ctlb_o) && $stable(ctlc_o) && $stable(vol_o));
  // R7: reserved selectors leave all state alone
  p_rsv_sel_r7: assert property (@(posedge clk) disable iff (rst)
    commit_i && sel > SEL_CTLC |=> $stable(ctla_o) && $stable(ctlb_o) && $stable(ctlc_o) && $stable(vol_o));
  // R8: nonzero reserved bits discard the word
  p_rsv_bits_r8: assert property (@(posedge clk) disable iff (rst)
    commit_i && rsv != '0 |=> $stable(ctla_o) && $stable(ctlb_o) && $stable(ctlc_o) && $stable(vol_o));
  // R1: state right after reset
  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> vol_o == '1 && ctla_o == '0 && ctlb_o == '0 && ctlc_o == '0);
  // R8: stored control words never hold an undefined code
  p_no_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
    ctla_o[1:0] != 2'b11 && ctla_o[4:3] != 2'b11 && ctlc_o[4:3] != 2'b11);
endmodule

// File: rtl/scp_top.sv
`timescale 1ns/1ps
module scp_top
  import scp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_latch,
  output logic [1:0]  deemph_sel,
  output logic [2:0]  fmt_sel,
  output logic [1:0]  wlen_sel,
  output logic        pwr_down,
  output logic [1:0]  interp_sel,
  output logic [5:0]  mute,
  output logic        stereo_copy,
  output logic [1:0]  mclk_factor,
  output logic        zflag_low,
  output logic        tdm_slave,
  output logic [NUM_VOL*PAY_BITS-1:0] vol
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] raw, lvl, rise;
  logic              commit;
  logic [WORD_BITS-1:0] word;
  logic [PAY_BITS-1:0]  ctla, ctlb, ctlc;

  assign raw = {ser_latch, ser_dat, ser_clk};

  for (genvar i = 0; i < NLINES; i++) begin : g_sync
    scp_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst(rst), .d_i(raw[i]), .lvl_o(lvl[i]), .rise_o(rise[i]));
  end

  scp_shifter #(.WB(WORD_BITS)) u_shift (
    .clk(clk), .rst(rst),
    .bit_stb_i(rise[0]), .bit_i(lvl[1]), .latch_stb_i(rise[2]),
    .commit_o(commit), .word_o(word));

  scp_regfile #(.WB(WORD_BITS), .AW(SEL_BITS), .DW(PAY_BITS), .NV(NUM_VOL)) u_regs (
    .clk(clk), .rst(rst), .commit_i(commit), .word_i(word),
    .ctla_o(ctla), .ctlb_o(ctlb), .ctlc_o(ctlc), .vol_o(vol));

  assign deemph_sel  = ctla[9:8];
  assign fmt_sel     = ctla[7:5];
  assign wlen_sel    = ctla[4:3];
  assign pwr_down    = ctla[2];
  assign interp_sel  = ctla[1:0];
  assign mute        = ctlb[5:0];
  assign stereo_copy = ctlc[5];
  assign mclk_factor = ctlc[4:3];
  assign zflag_low   = ctlc[2];
  assign tdm_slave   = ctlc[0];

  logic unused_ok;
  assign unused_ok = ^{lvl[2], lvl[0], rise[1], ctlb[9:6], ctlc[9:6], ctlc[1]};
endmodule

// File: tb/scp_top_test.sv
`timescale 1ns/1ps
module scp_top_test;
  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_dat = 0, ser_latch = 0;
  logic [1:0] deemph_sel, wlen_sel, interp_sel, mclk_factor;
  logic [2:0] fmt_sel;
  logic pwr_down, stereo_copy, zflag_low, tdm_slave;
  logic [5:0] mute;
  logic [59:0] vol;

  int checks = 0, errors = 0;
  int pend = 0;
  logic [9:0] e_a, e_b, e_c;
  logic [9:0] e_v [6];

  always #4 clk = ~clk;

  scp_top uut (.*);

  task automatic tick4();
    repeat (4) @(posedge clk);
    #1;
  endtask

  function automatic bit word_ok(input logic [15:0] w);
    logic [3:0] s; logic [9:0] d;
    s = w[15:12]; d = w[9:0];
    if (w[11:10] != 2'b00) return 0;
    if (s == 4'h0) return d[7:5] != 3'b111 && d[4:3] != 2'b11 && d[1:0] != 2'b11;
    if (s == 4'h1) return d[9:6] == 4'b0;
    if (s == 4'h8) return d[9:6] == 4'b0 && !d[1] && d[4:3] != 2'b11;
    if (s >= 4'h2 && s <= 4'h7) return 1;
    return 0;
  endfunction

  task automatic model_apply(input logic [15:0] w);
    if (!word_ok(w)) return;
    case (w[15:12])
      4'h0: e_a = w[9:0];
      4'h1: e_b = w[9:0];
      4'h8: e_c = w[9:0];
      default: e_v[w[15:12] - 4'h2] = w[9:0];
    endcase
  endtask

  task automatic send(input logic [31:0] v, input int n, input bit do_latch);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      tick4();
      ser_clk = 1;
      tick4();
      ser_clk = 0;
    end
    pend += n;
    if (do_latch) begin
      tick4();
      ser_latch = 1;
      tick4();
      ser_latch = 0;
      if (pend == 16) model_apply(v[15:0]);
      pend = 0;
    end
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [59:0] ev;
    for (int k = 0; k < 6; k++) ev[k*10 +: 10] = e_v[k];
    chk(tag, 64'(deemph_sel), 64'(e_a[9:8]), "deemph_sel");
    chk(tag, 64'(fmt_sel), 64'(e_a[7:5]), "fmt_sel");
    chk(tag, 64'(wlen_sel), 64'(e_a[4:3]), "wlen_sel");
    chk(tag, 64'(pwr_down), 64'(e_a[2]), "pwr_down");
    chk(tag, 64'(interp_sel), 64'(e_a[1:0]), "interp_sel");
    chk(tag, 64'(mute), 64'(e_b[5:0]), "mute");
    chk(tag, 64'(stereo_copy), 64'(e_c[5]), "stereo_copy");
    chk(tag, 64'(mclk_factor), 64'(e_c[4:3]), "mclk_factor");
    chk(tag, 64'(zflag_low), 64'(e_c[2]), "zflag_low");
    chk(tag, 64'(tdm_slave), 64'(e_c[0]), "tdm_slave");
    chk(tag, 64'(vol), 64'(ev), "vol");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 got hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] w;
    int n;
    e_a = '0; e_b = '0; e_c = '0;
    for (int k = 0; k < 6; k++) e_v[k] = 10'h3FF;
    void'($urandom(32'd20240601));
    repeat (5) @(posedge clk);
    #1 rst = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check_all("R1");

    // R4 control word A fields: deemph 01, fmt LJ 011, wlen 16 (10), pd 1, interp 4x (10)
    send({16'h0000, 4'h0, 2'b00, 2'b01, 3'b011, 2'b10, 1'b1, 2'b10}, 16, 1);
    check_all("R4");
    // R5 mute bits, channel 1 at bit 0
    send({16'h0000, 4'h1, 2'b00, 4'b0000, 6'b100101}, 16, 1);
    check_all("R5");
    // R6 control word C: copy 1, factor x2/3 (10), zero low 1, slave 1
    send({16'h0000, 4'h8, 2'b00, 4'b0000, 1'b1, 2'b10, 1'b1, 1'b0, 1'b1}, 16, 1);
    check_all("R6");
    // R3 volume map, distinct value per channel
    for (int k = 0; k < 6; k++) begin
      send({16'h0000, 4'(k + 2), 2'b00, 10'(10'h051 * (k + 1))}, 16, 1);
      check_all("R3");
    end
    // R7 reserved selectors
    send({16'h0000, 4'h9, 2'b00, 10'h000}, 16, 1);
    check_all("R7");
    send({16'h0000, 4'hF, 2'b00, 10'h2AA}, 16, 1);
    check_all("R7");
    // R8 undefined codes and reserved bits
    send({16'h0000, 4'h0, 2'b00, 10'b00_111_00_0_00}, 16, 1);
    check_all("R8");
    send({16'h0000, 4'h0, 2'b00, 10'b00_000_00_0_11}, 16, 1);
    check_all("R8");
    send({16'h0000, 4'h8, 2'b00, 10'b0000_0_11_0_0_0}, 16, 1);
    check_all("R8");
    send({16'h0000, 4'h1, 2'b00, 10'b0010_000000}, 16, 1);
    check_all("R8");
    send({16'h0000, 4'h3, 2'b01, 10'h000}, 16, 1);
    check_all("R8");
    // R9 wrong counts then a good word
    send({16'h0000, 4'h2, 2'b00, 10'h000}, 15, 1);
    check_all("R9");
    send({15'h0000, 1'b1, 4'h2, 2'b00, 10'h001}, 17, 1);
    check_all("R9");
    send({16'h0000, 4'h2, 2'b00, 10'h155}, 16, 1);
    check_all("R9");
    // R10 serial clocks without latch change nothing, then overlong word drops
    send({16'h0000, 4'h4, 2'b00, 10'h000}, 16, 0);
    check_all("R10");
    send({16'h0000, 4'h4, 2'b00, 10'h001}, 16, 1);
    check_all("R10");
    send({16'h0000, 4'h4, 2'b00, 10'h002}, 16, 1);
    check_all("R2");

    // random commands
    for (int t = 0; t < 48; t++) begin
      r = $urandom();
      w[15:12] = (r[3:0] > 4'hB) ? 4'h8 : r[3:0];
      w[11:10] = (r[6:4] == 3'b000) ? r[8:7] : 2'b00;
      w[9:0]   = 10'($urandom());
      if (w[15:12] == 4'h1 && r[9]) w[9:6] = 4'b0;
      if (w[15:12] == 4'h8 && r[9]) begin w[9:6] = 4'b0; w[1] = 1'b0; end
      n = (r[14:12] == 3'b000) ? 15 : (r[14:12] == 3'b001) ? 17 : 16;
      send({16'h0000, w}, n, 1);
      check_all("R10");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule